// File: doc/BRIEF.md
# Selectable Arithmetic, Logic and Shift Execution Unit

This block is a purely combinational execution unit for a 32-bit datapath. Three sub-units work side by side on the same pair of operands. The first is an adder/subtractor. The second is a logic unit whose per-bit behaviour comes from a 4-bit truth table. The third is a barrel shifter that does logical, arithmetic and rotate moves in either direction. A 2-bit unit selector picks which sub-unit's result reaches the output, or switches the output off entirely.

Decode logic upstream drives the control inputs for each operation. The operands come from a register file or an immediate path. Alongside the result, the unit reports a carry, a signed overflow and a zero indication. The result and flags settle in the same cycle the inputs change; there are no registers inside.

Top module: `alsu_core`

## Requirements
- R1: With `unit_i` = 2'b11 the result is all zeros, `carry_o` and `ovf_o` are 0 and `zero_o` is 1, whatever the other inputs are.
- R2: With `unit_i` = 2'b00 and `sub_i` = 0 the result is `opa_i + opb_i + carry_i` modulo 2^32. With `sub_i` = 1 it is `opa_i + ~opb_i + 1`, which is `opa_i - opb_i`, and `carry_i` has no effect.
- R3: In adder mode `carry_o` is bit 32 of the unsigned 33-bit sum formed as in R2. On a subtract this means 1 when there is no borrow.
- R4: In adder mode `ovf_o` is 1 exactly when the signed two's-complement result of the add or subtract does not fit in 32 bits.
- R5: When `unit_i` is not 2'b00, `carry_o` and `ovf_o` are both 0.
- R6: With `unit_i` = 2'b01, result bit n equals `func_i[{~opa_i[n], ~opb_i[n]}]`. Index 0 is used when a=1,b=1, index 1 when a=1,b=0, index 2 when a=0,b=1 and index 3 when a=0,b=0. So 0001 gives AND, 0011 passes A, 0101 passes B, 0110 gives XOR and 0111 gives OR.
- R7: With `unit_i` = 2'b10 and `shkind_i` = 2'b00 the result equals `opa_i` unshifted.
- R8: `shkind_i` = 2'b01 is a logical shift of `opa_i` that fills with zeros. It goes left when `shright_i` = 0 and right when `shright_i` = 1.
- R9: `shkind_i` = 2'b10 to the right fills with copies of `opa_i[31]`. To the left it behaves the same as a logical left shift.
- R10: `shkind_i` = 2'b11 rotates `opa_i`, left or right as set by `shright_i`, with the bits that leave one end entering at the other.
- R11: The shift amount is `opb_i[4:0]`. Bits 31:5 of `opb_i` have no effect on any shift.
- R12: `zero_o` is 1 exactly when the selected 32-bit result is all zeros, in every unit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand; the value that is shifted |
| opb_i | input | 32 | Second operand; its low 5 bits give the shift amount |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| carry_i | input | 1 | Carry into the add (not used on subtract) |
| func_i | input | 4 | Truth table of the logic unit |
| shkind_i | input | 2 | 00 none, 01 logical, 10 arithmetic, 11 rotate |
| shright_i | input | 1 | 0 = left, 1 = right |
| unit_i | input | 2 | 00 adder, 01 logic, 10 shifter, 11 off |
| res_o | output | 32 | Selected result |
| carry_o | output | 1 | Adder carry out |
| ovf_o | output | 1 | Signed overflow |
| zero_o | output | 1 | Result is zero |

## Verification
The embedded checks are immediate and evaluate whenever the operand and control inputs change. They therefore assume that every input holds a defined 0 or 1 value, with no unknowns. The bench drives all control and operand inputs to defined values from time zero onward. It changes them only on the falling clock edge, so each combination settles for half a period before it is compared. The directed vectors cover the full-scale corners: all-ones, the sign bit alone, and shift amounts 0 and 31. Pseudo-random vectors come from a fixed-seed xorshift generator, and their control fields are always within the ranges the block defines.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b01,
    UNIT_SHIFT = 2'b10,
    UNIT_OFF   = 2'b11
  } unit_sel_e;

  typedef enum logic [1:0] {
    SHK_NONE    = 2'b00,
    SHK_LOGICAL = 2'b01,
    SHK_ARITH   = 2'b10,
    SHK_ROTATE  = 2'b11
  } shift_kind_e;

  localparam logic [3:0] FUNC_PASS_A = 4'b0011;

endpackage

// File: rtl/alsu_addsub.sv
module alsu_addsub #(
  parameter int W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  logic [W-1:0] b_op;
  logic         cin_eff;
  logic [W:0]   total;
  logic         ovf_raw;

  always_comb begin
    b_op    = sub_i ? ~b_i : b_i;
    cin_eff = sub_i ? 1'b1 : cin_i;
    total   = {1'b0, a_i} + {1'b0, b_op} + {{W{1'b0}}, cin_eff};
    ovf_raw = (a_i[W-1] == b_op[W-1]) && (total[W-1] != a_i[W-1]);
  end

  always_comb begin
    sum_o  = en_i ? total[W-1:0] : '0;
    cout_o = en_i & total[W];
    ovf_o  = en_i & ovf_raw;
  end

  always_comb begin
    if (en_i && sub_i && (a_i == b_i)) begin
      AST_SUB_SELF_ZERO: assert ((sum_o == '0) && cout_o && !ovf_o); // R2
    end
    if (en_i && !sub_i && (a_i[W-1] != b_i[W-1])) begin
      AST_NO_OVERFLOW: assert (!ovf_o); // R4
    end
    if (!en_i) begin
      AST_IDLE_FLAGS: assert (!cout_o && !ovf_o && (sum_o == '0)); // R5
    end
  end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
  parameter int W = 32
) (
  input  logic         en_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   func_i,
  output logic [W-1:0] f_o
);
  import alsu_pkg::*;

  logic [W-1:0] bitfn;

  for (genvar n = 0; n < W; n++) begin : g_slice
    logic [1:0] idx;
    assign idx      = {~a_i[n], ~b_i[n]};
    assign bitfn[n] = func_i[idx];
  end

  assign f_o = en_i ? bitfn : '0;

  always_comb begin
    if (en_i && (func_i == FUNC_PASS_A)) begin
      AST_PASS_A: assert (f_o == a_i); // R6
    end
    if (en_i && (func_i == 4'b0000)) begin
      AST_ALL_ZERO_TABLE: assert (f_o == '0); // R6
    end
  end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic           en_i,
  input  logic [W-1:0]   a_i,
  input  logic [SHW-1:0] amt_i,
  input  logic [1:0]     kind_i,
  input  logic           right_i,
  output logic [W-1:0]   r_o
);
  import alsu_pkg::*;

  logic [W-1:0] src;
  logic [W-1:0] stg [SHW+1];
  logic [W-1:0] moved;
  logic [W-1:0] shaped;
  logic         rot;
  logic         sign_fill;

  function automatic logic [W-1:0] flip(input logic [W-1:0] v);
    logic [W-1:0] t;
    for (int i = 0; i < W; i++) t[i] = v[W-1-i];
    return t;
  endfunction

  always_comb begin
    rot       = (kind_i == SHK_ROTATE);
    sign_fill = (kind_i == SHK_ARITH) && right_i && a_i[W-1];
    src       = right_i ? a_i : flip(a_i);
  end

  assign stg[0] = src;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int D = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i + D < W) begin : g_in
        assign stg[k+1][i] = amt_i[k] ? stg[k][i+D] : stg[k][i];
      end else begin : g_edge
        assign stg[k+1][i] = !amt_i[k] ? stg[k][i] :
                             (rot ? stg[k][i+D-W] : sign_fill);
      end
    end
  end

  always_comb begin
    moved  = right_i ? stg[SHW] : flip(stg[SHW]);
    shaped = (kind_i == SHK_NONE) ? a_i : moved;
    r_o    = en_i ? shaped : '0;
  end

  always_comb begin
    if (en_i && (kind_i == SHK_NONE)) begin
      AST_SHIFT_NONE: assert (r_o == a_i); // R7
    end
    if (en_i && (kind_i == SHK_ROTATE)) begin
      AST_ROT_KEEPS_ONES: assert ($countones(r_o) == $countones(a_i)); // R10
    end
    if (en_i && (amt_i == '0)) begin
      AST_ZERO_AMOUNT: assert (r_o == a_i); // R8
    end
  end

endmodule

// File: rtl/alsu_core.sv
module alsu_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         sub_i,
  input  logic         carry_i,
  input  logic [3:0]   func_i,
  input  logic [1:0]   shkind_i,
  input  logic         shright_i,
  input  logic [1:0]   unit_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         zero_o
);
  import alsu_pkg::*;

  localparam int SHW = $clog2(W);

  logic         en_arith;
  logic         en_logic;
  logic         en_shift;
  logic [W-1:0] arith_r;
  logic [W-1:0] logic_r;
  logic [W-1:0] shift_r;
  logic         arith_c;
  logic         arith_v;

  always_comb begin
    en_arith = (unit_i == UNIT_ARITH);
    en_logic = (unit_i == UNIT_LOGIC);
    en_shift = (unit_i == UNIT_SHIFT);
  end

  alsu_addsub #(.W(W)) u_addsub (
    .en_i   (en_arith),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (sub_i),
    .cin_i  (carry_i),
    .sum_o  (arith_r),
    .cout_o (arith_c),
    .ovf_o  (arith_v)
  );

  alsu_logic #(.W(W)) u_logic (
    .en_i   (en_logic),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .func_i (func_i),
    .f_o    (logic_r)
  );

  alsu_shift #(.W(W), .SHW(SHW)) u_shift (
    .en_i    (en_shift),
    .a_i     (opa_i),
    .amt_i   (opb_i[SHW-1:0]),
    .kind_i  (shkind_i),
    .right_i (shright_i),
    .r_o     (shift_r)
  );

  always_comb begin
    res_o   = arith_r | logic_r | shift_r;
    carry_o = arith_c;
    ovf_o   = arith_v;
    zero_o  = ~|res_o;
  end

  always_comb begin
    AST_ONE_SOURCE: assert ($countones({|arith_r, |logic_r, |shift_r}) <= 1); // R1
    if (unit_i == UNIT_OFF) begin
      AST_OFF_QUIET: assert ((res_o == '0) && zero_o && !carry_o && !ovf_o); // R1
    end
    if (unit_i != UNIT_ARITH) begin
      AST_FLAGS_GATED: assert (!carry_o && !ovf_o); // R5
    end
  end

endmodule

// File: tb/alsu_core_tb_top.sv
module alsu_core_tb_top;

  typedef struct {
    logic [31:0] res;
    logic        c;
    logic        v;
    logic        z;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] opa, opb;
  logic        sub, cin, shright;
  logic [3:0]  func;
  logic [1:0]  shkind, unit;
  logic [31:0] res;
  logic        carry, ovf, zero;

  exp_t        sb_q [$];
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 0;
  logic [31:0] seed = 32'h1badf00d;

  alsu_core #(.W(32)) dut_i (
    .opa_i(opa), .opb_i(opb), .sub_i(sub), .carry_i(cin), .func_i(func),
    .shkind_i(shkind), .shright_i(shright), .unit_i(unit),
    .res_o(res), .carry_o(carry), .ovf_o(ovf), .zero_o(zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                 input logic s, input logic ci, input logic [3:0] lf,
                                 input logic [1:0] sk, input logic sr, input logic [1:0] u);
    exp_t        e;
    logic [32:0] t;
    longint      sv;
    logic [63:0] w;
    int          amt;
    e.c = 1'b0; e.v = 1'b0; e.res = '0; e.tag = "";
    amt = int'(b[4:0]);
    case (u)
      2'b00: begin
        if (s) begin
          t  = {1'b0, a} + {1'b0, ~b} + 33'd1;
          sv = longint'($signed(a)) - longint'($signed(b));
        end else begin
          t  = {1'b0, a} + {1'b0, b} + {32'd0, ci};
          sv = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
        end
        e.res = t[31:0];
        e.c   = t[32];
        e.v   = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
      end
      2'b01: begin
        for (int n = 0; n < 32; n++) begin
          case ({a[n], b[n]})
            2'b11: e.res[n] = lf[0];
            2'b10: e.res[n] = lf[1];
            2'b01: e.res[n] = lf[2];
            default: e.res[n] = lf[3];
          endcase
        end
      end
      2'b10: begin
        case (sk)
          2'b00: e.res = a;
          2'b01: e.res = sr ? (a >> amt) : (a << amt);
          2'b10: e.res = sr ? 32'($signed(a) >>> amt) : (a << amt);
          default: begin
            if (sr) begin w = {a, a} >> amt; e.res = w[31:0]; end
            else    begin w = {a, a} << amt; e.res = w[63:32]; end
          end
        endcase
      end
      default: e.res = '0;
    endcase
    e.z = (e.res == 32'd0);
    return e;
  endfunction

  task automatic drive(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic ci, input logic [3:0] lf,
                       input logic [1:0] sk, input logic sr, input logic [1:0] u);
    exp_t e;
    @(negedge clk);
    opa = a; opb = b; sub = s; cin = ci; func = lf; shkind = sk; shright = sr; unit = u;
    e = model(a, b, s, ci, lf, sk, sr, u);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (res !== e.res || carry !== e.c || ovf !== e.v || zero !== e.z) begin
        n_errors++;
        $display("FAIL %s: got res=%h c=%b v=%b z=%b expected res=%h c=%b v=%b z=%b",
                 e.tag, res, carry, ovf, zero, e.res, e.c, e.v, e.z);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; sub = 0; cin = 0; func = '0; shkind = '0; shright = 0; unit = 2'b11;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset / disabled state: R1
    drive("R1 off", 32'h0, 32'h0, 0, 0, 4'h0, 2'b00, 0, 2'b11);
    drive("R1 off busy inputs", 32'hffffffff, 32'h1, 0, 1, 4'hf, 2'b11, 1, 2'b11);
    // adder: R2 R3 R4 R12
    drive("R2 add cin", 32'd5, 32'd7, 0, 1, 4'h0, 2'b00, 0, 2'b00);
    drive("R3 add wrap carry", 32'hffffffff, 32'd1, 0, 0, 4'h0, 2'b00, 0, 2'b00);
    drive("R12 zero from add", 32'hffffffff, 32'd1, 0, 0, 4'h0, 2'b00, 0, 2'b00);
    drive("R4 add overflow", 32'h7fffffff, 32'd1, 0, 0, 4'h0, 2'b00, 0, 2'b00);
    drive("R4 sub overflow", 32'h80000000, 32'd1, 1, 0, 4'h0, 2'b00, 0, 2'b00);
    drive("R2 sub ignores cin", 32'd10, 32'd3, 1, 1, 4'h0, 2'b00, 0, 2'b00);
    drive("R3 sub borrow", 32'd3, 32'd10, 1, 0, 4'h0, 2'b00, 0, 2'b00);
    // logic: R5 R6
    drive("R6 AND", 32'hf0f0ff00, 32'hff00f0f0, 0, 1, 4'b0001, 2'b00, 0, 2'b01);
    drive("R6 pass A", 32'h12345678, 32'hffffffff, 0, 0, 4'b0011, 2'b00, 0, 2'b01);
    drive("R6 pass B", 32'h12345678, 32'h9abcdef0, 0, 0, 4'b0101, 2'b00, 0, 2'b01);
    drive("R6 XOR", 32'hf0f0ff00, 32'hff00f0f0, 0, 0, 4'b0110, 2'b00, 0, 2'b01);
    drive("R6 OR", 32'hf0f0ff00, 32'hff00f0f0, 0, 0, 4'b0111, 2'b00, 0, 2'b01);
    drive("R6 NOR", 32'hf0f0ff00, 32'hff00f0f0, 0, 0, 4'b1000, 2'b00, 0, 2'b01);
    drive("R5 flags off in logic", 32'hffffffff, 32'hffffffff, 0, 1, 4'b0001, 2'b00, 0, 2'b01);
    // shifter: R7..R11
    drive("R7 no shift", 32'h80000001, 32'd4, 0, 0, 4'h0, 2'b00, 1, 2'b10);
    drive("R8 lsl", 32'h80000001, 32'd4, 0, 0, 4'h0, 2'b01, 0, 2'b10);
    drive("R8 lsr", 32'h80000001, 32'd31, 0, 0, 4'h0, 2'b01, 1, 2'b10);
    drive("R9 asr neg", 32'h80000000, 32'd31, 0, 0, 4'h0, 2'b10, 1, 2'b10);
    drive("R9 asr pos", 32'h40000000, 32'd3, 0, 0, 4'h0, 2'b10, 1, 2'b10);
    drive("R9 asl", 32'hc0000003, 32'd1, 0, 0, 4'h0, 2'b10, 0, 2'b10);
    drive("R10 rotl", 32'h80000001, 32'd1, 0, 0, 4'h0, 2'b11, 0, 2'b10);
    drive("R10 rotr", 32'h80000001, 32'd1, 0, 0, 4'h0, 2'b11, 1, 2'b10);
    drive("R10 rotr 31", 32'h0000000f, 32'd31, 0, 0, 4'h0, 2'b11, 1, 2'b10);
    drive("R11 upper amount bits", 32'h0000ff00, 32'hffffffe4, 0, 0, 4'h0, 2'b01, 1, 2'b10);
    drive("R11 amount 32 is 0", 32'h0000ff00, 32'h00000020, 0, 0, 4'h0, 2'b01, 0, 2'b10);
    drive("R12 zero from shift", 32'h00000001, 32'd1, 0, 0, 4'h0, 2'b01, 1, 2'b10);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b, c;
      a = rnd(); b = rnd(); c = rnd();
      if (c[10]) a = a & 32'h8000ffff;
      drive("R2/R6/R8/R10 random", a, b, c[0], c[1], c[5:2], c[7:6], c[8], c[12:11]);
    end

    @(negedge clk);
    while (sb_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule